// File: doc/BRIEF.md
# Multi-mode serial bit-rate generator

This block produces the bit timing for one channel of a serial port. A counter chain divides the system clock and raises a one-cycle `bitTick` once per bit period. In asynchronous mode it also raises `sampleTick` sixteen times per bit, which a receiver uses for oversampling. Each channel gets its own instance, so two channels can run at different rates without sharing any state.

The chain has three stages. A prescaler divides by 4^n, with n taken from `clkSel`. An (N+1) divider follows, where N is the 8-bit divisor held in the block. The last stage divides by a factor that depends on the mode: 32 for asynchronous, 4 for clocked synchronous, and 2·S for smart-card. S is picked by `cardFactor`. Software can write the divisor through a simple write strobe at any time and can always read it back. A write, or any change of the mode or select inputs, restarts the chain from zero, so the next period is a full period at the new setting. Pulling `enable` low holds every counter at zero.

Top module: `serial_rate_gen`

## Requirements
- R1: After reset the divisor reads 0xFF on `rdData`. A write with `wrEn` high updates `rdData` to `wrData` from the next cycle onward.
- R2: In asynchronous mode (`cardMode`=0, `syncMode`=0) successive `bitTick` pulses are 32·4^n·(N+1) cycles apart, where n is the value of `clkSel`.
- R3: In clocked synchronous mode (`cardMode`=0, `syncMode`=1) successive `bitTick` pulses are 4·4^n·(N+1) cycles apart.
- R4: In smart-card mode the spacing is 2·S·4^n·(N+1) cycles. `cardFactor` selects S as follows: 0→32, 1→64, 2→372, 3→256.
- R5: In asynchronous mode `sampleTick` pulses every 2·4^n·(N+1) cycles, which gives 16 pulses per bit period, and one of them coincides with each `bitTick`. In the other modes `sampleTick` stays low.
- R6: When `cardMode` is 1 the channel uses smart-card timing, whatever the value of `syncMode`.
- R7: A divisor write, or a change of `clkSel`, `cardFactor`, `cardMode` or `syncMode`, in cycle w restarts the chain. The first `bitTick` after it comes in cycle w+P, where P is the period for the new setting. `bitTick` is low in cycle w+1.
- R8: While `enable` is low, neither tick is raised. Once `enable` is high, the first `bitTick` appears in the P-th cycle in which `enable` is high.
- R9: Every `bitTick` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the generator; when low, all counters are held at zero |
| wrEn | input | 1 | Divisor write strobe |
| wrData | input | 8 | Divisor value to write |
| rdData | output | 8 | Current divisor value |
| clkSel | input | 2 | Prescaler exponent n (divides by 4^n) |
| cardFactor | input | 2 | Smart-card factor S select |
| cardMode | input | 1 | 1 selects smart-card timing |
| syncMode | input | 1 | When `cardMode` is 0: 1 selects synchronous, 0 selects asynchronous |
| bitTick | output | 1 | One-cycle pulse per bit period |
| sampleTick | output | 1 | Pulse at 16 times the bit rate, asynchronous mode only |

## Verification
The properties assume that the mode and select inputs only change together with the restart they cause, and that every period is at least four cycles long, which is always true for the supported divide factors. The single-pulse check and the check for no tick right after a write rely on that minimum. The stimulus changes settings only on a falling clock edge, either together with a divisor write or as a deliberate change with no write. It then holds them steady for at least two full periods, so every measured spacing comes from one unbroken setting.

// File: rtl/rate_gen_pkg.sv
package rate_gen_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC = 2'd0,
    MODE_SYNC  = 2'd1,
    MODE_CARD  = 2'd2
  } rateMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic      clear;    // restart every stage
    logic      advance;  // prescaler terminal count
    rateMode_t mode;
  } rateStrobe_t;

  localparam int SEL_W = 2;
  localparam int PRE_W = 2 * ((1 << SEL_W) - 1);
  localparam int FIN_W = 10;
endpackage

// File: rtl/rate_ctrl.sv
module rate_ctrl
  import rate_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] clkSel,
  input  logic [1:0]       cardFactor,
  input  logic             cardMode,
  input  logic             syncMode,
  output rateStrobe_t      strobe
);
  localparam int CFG_W = SEL_W + 4;

  logic [CFG_W-1:0] cfgNow, cfgPrev;
  logic [PRE_W-1:0] presCnt, presTerm;
  logic             cfgChanged, clearNow, presWrap;

  assign cfgNow     = {clkSel, cardFactor, cardMode, syncMode};
  assign cfgChanged = cfgNow != cfgPrev;
  assign clearNow   = !enable || wrEn || cfgChanged;
  assign presTerm   = PRE_W'((32'd1 << (2 * clkSel)) - 32'd1);
  assign presWrap   = presCnt == presTerm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgPrev <= '0;
      presCnt <= '0;
    end else begin
      cfgPrev <= cfgNow;
      if (clearNow || presWrap) presCnt <= '0;
      else                      presCnt <= presCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.clear   = clearNow;
    strobe.advance = presWrap && !clearNow;
    if (cardMode)      strobe.mode = MODE_CARD;
    else if (syncMode) strobe.mode = MODE_SYNC;
    else               strobe.mode = MODE_ASYNC;
  end

  // R7: a restart leaves the prescaler at zero
  a_r7_prescaler_restart: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> presCnt == '0);
endmodule

// File: rtl/rate_datapath.sv
module rate_datapath
  import rate_gen_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = '1
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [DIV_W-1:0] wrData,
  input  logic [1:0]       cardFactor,
  input  rateStrobe_t      strobe,
  output logic [DIV_W-1:0] rdData,
  output logic             bitTick,
  output logic             sampleTick
);
  logic [DIV_W-1:0] divReg, midCnt;
  logic [FIN_W-1:0] finCnt, finTerm;
  logic             midWrap, finWrap;

  // Last-stage terminal count (divide factor minus one)
  always_comb begin
    unique case (strobe.mode)
      MODE_ASYNC: finTerm = FIN_W'(31);
      MODE_SYNC:  finTerm = FIN_W'(3);
      default: begin
        unique case (cardFactor)
          2'd0:    finTerm = FIN_W'(63);
          2'd1:    finTerm = FIN_W'(127);
          2'd2:    finTerm = FIN_W'(743);
          default: finTerm = FIN_W'(511);
        endcase
      end
    endcase
  end

  assign midWrap = strobe.advance && (midCnt == divReg);
  assign finWrap = finCnt == finTerm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg <= DIV_RESET;
      midCnt <= '0;
      finCnt <= '0;
    end else begin
      if (wrEn) divReg <= wrData;
      if (strobe.clear)        midCnt <= '0;
      else if (strobe.advance) midCnt <= midWrap ? '0 : midCnt + 1'b1;
      if (strobe.clear)        finCnt <= '0;
      else if (midWrap)        finCnt <= finWrap ? '0 : finCnt + 1'b1;
    end
  end

  assign rdData     = divReg;
  assign bitTick    = midWrap && finWrap;
  assign sampleTick = midWrap && (strobe.mode == MODE_ASYNC) && finCnt[0];

  // R7: the middle stage restarts with the prescaler
  a_r7_mid_restart: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> midCnt == '0 && finCnt == '0);
endmodule

// File: rtl/serial_rate_gen.sv
module serial_rate_gen
  import rate_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic [1:0] clkSel,
  input  logic [1:0] cardFactor,
  input  logic       cardMode,
  input  logic       syncMode,
  output logic       bitTick,
  output logic       sampleTick
);
  rateStrobe_t strobe;

  rate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .wrEn(wrEn),
    .clkSel(clkSel), .cardFactor(cardFactor),
    .cardMode(cardMode), .syncMode(syncMode), .strobe(strobe)
  );

  rate_datapath #(.DIV_W(8), .DIV_RESET(8'hFF)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .cardFactor(cardFactor), .strobe(strobe),
    .rdData(rdData), .bitTick(bitTick), .sampleTick(sampleTick)
  );

  a_r1_write_visible: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData == $past(wrData));
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |=> !bitTick);
  a_r8_quiet_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !bitTick && !sampleTick);
  a_r5_sample_async_only: assert property (@(posedge clk) disable iff (!rstN)
    (cardMode || syncMode) |-> !sampleTick);
  a_r5_bit_with_sample: assert property (@(posedge clk) disable iff (!rstN)
    (bitTick && !cardMode && !syncMode) |-> sampleTick);
  a_r7_no_tick_after_write: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !bitTick);
endmodule

// File: tb/serial_rate_gen_test.sv
module serial_rate_gen_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0, enable = 1'b0, wrEn = 1'b0;
  logic [7:0] wrData = '0, rdData;
  logic [1:0] clkSel = '0, cardFactor = '0;
  logic       cardMode = 1'b0, syncMode = 1'b0, bitTick, sampleTick;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  serial_rate_gen uut (
    .clk(clk), .rstN(rstN), .enable(enable), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .clkSel(clkSel), .cardFactor(cardFactor),
    .cardMode(cardMode), .syncMode(syncMode),
    .bitTick(bitTick), .sampleTick(sampleTick)
  );

  // {mode[1]=card,mode[0]=sync, factor, n, N, expected period}
  localparam int NROW = 13;
  localparam logic [45:0] VEC [NROW] = '{
    {2'd0, 2'd0, 2'd0, 8'd0,   32'd32},
    {2'd0, 2'd0, 2'd1, 8'd1,   32'd256},
    {2'd0, 2'd0, 2'd3, 8'd0,   32'd2048},
    {2'd0, 2'd0, 2'd0, 8'd255, 32'd8192},
    {2'd1, 2'd0, 2'd0, 8'd0,   32'd4},
    {2'd1, 2'd0, 2'd2, 8'd1,   32'd128},
    {2'd1, 2'd0, 2'd1, 8'd255, 32'd4096},
    {2'd2, 2'd0, 2'd0, 8'd0,   32'd64},
    {2'd2, 2'd1, 2'd1, 8'd0,   32'd512},
    {2'd2, 2'd2, 2'd0, 8'd1,   32'd1488},
    {2'd2, 2'd3, 2'd2, 8'd0,   32'd8192},
    {2'd2, 2'd2, 2'd1, 8'd0,   32'd2976},
    {2'd3, 2'd0, 2'd0, 8'd0,   32'd64}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // Waits up to limit cycles for a bitTick; the current cycle counts as 1
  task automatic waitTick(input int limit, output int at);
    at = -1;
    for (int k = 1; k <= limit; k++) begin
      if (bitTick) begin at = k; break; end
      step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int at;
    repeat (3) step();
    check(rdData == 8'hFF, "R1 reset divisor", rdData, 255);
    check(!bitTick && !sampleTick, "R8 no tick in reset", bitTick, 0);
    @(negedge clk); rstN = 1'b1; enable = 1'b1;

    foreach (VEC[i]) begin
      logic [1:0] m, f, n;
      logic [7:0] nd;
      int per, firstAt, secondAt, firstSample, between, k;
      string req;
      {m, f, n, nd, per} = VEC[i];
      req = m == 2'd0 ? "R2" : m == 2'd1 ? "R3" : m == 2'd2 ? "R4" : "R6";
      @(negedge clk);
      cardMode = m[1]; syncMode = m[0]; cardFactor = f; clkSel = n;
      wrData = nd; wrEn = 1'b1;
      @(negedge clk); wrEn = 1'b0; #1;
      check(rdData == nd, "R1 readback", rdData, nd);
      check(!bitTick, "R7 no tick after write", bitTick, 0);
      k = 1; firstAt = -1; secondAt = -1; firstSample = -1; between = 0;
      while (secondAt < 0 && k <= 3 * per + 8) begin
        if (sampleTick && firstSample < 0) firstSample = k;
        if (firstAt >= 0 && sampleTick) between++;
        if (bitTick) begin
          if (firstAt < 0) firstAt = k;
          else secondAt = k;
        end
        if (secondAt < 0) begin step(); k++; end
      end
      check(firstAt == per, {"R7 first tick ", req}, firstAt, per);
      check(secondAt - firstAt == per, {req, " period"}, secondAt - firstAt, per);
      if (m == 2'd0) begin
        check(between == 16, "R5 samples per bit", between, 16);
        check(firstSample == per / 16, "R5 sample spacing", firstSample, per / 16);
      end else begin
        check(between == 0 && firstSample < 0, "R5 no samples off async", between, 0);
      end
    end

    // R9: pulse width in the shortest mode (sync, n=0, N=0)
    @(negedge clk);
    cardMode = 1'b0; syncMode = 1'b1; clkSel = 2'd0; wrData = 8'd0; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; #1;
    waitTick(10, at);
    step();
    check(at == 4 && !bitTick, "R9 single cycle pulse", bitTick, 0);

    // R7: a select change alone restarts (async, N=0, n 0 -> 1, P=128)
    @(negedge clk); syncMode = 1'b0; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    repeat (10) @(negedge clk);
    clkSel = 2'd1;
    step();
    waitTick(400, at);
    check(at == 128, "R7 restart on select change", at, 128);

    // R8: disabled generator is silent, then restarts cleanly (P=128)
    @(negedge clk); enable = 1'b0;
    begin
      int seen = 0;
      for (int c = 0; c < 300; c++) begin
        step();
        if (bitTick || sampleTick) seen++;
      end
      check(seen == 0, "R8 quiet while disabled", seen, 0);
    end
    @(negedge clk); enable = 1'b1; #1;
    waitTick(400, at);
    check(at == 128, "R8 first tick after enable", at, 128);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule